// File: doc/BRIEF.md
# I2C Slave Overrun and Underrun Handler

This block sits between the bit-level engine of an I2C slave and the software-facing registers. It covers the case where clock stretching is turned off. There, the slave cannot hold SCL low while software catches up. The bus-side shell reports each completed received byte as a one-cycle pulse. It also asks for each byte to transmit with a one-cycle request. The block keeps a single-byte receive holding slot and a single-byte transmit holding slot, and each slot has its own state machine.

When the block runs as a slave with stretching off, it watches for software falling behind the bus:
- A byte that arrives while the previous one is still unread is dropped, and the block tells the shell to answer it with NACK.
- A transmit request that finds no fresh byte is served with an all-ones fill byte.

Either event raises a sticky error flag. The flag drives an interrupt request when error interrupts are enabled.

The receive slot has two states: `RX_IDLE` (empty) and `RX_HELD` (holding a byte). Its transitions are:
- load: `RX_IDLE`→`RX_HELD`
- drain: `RX_HELD`→`RX_IDLE` on read
- reload: `RX_HELD`→`RX_HELD` on read plus arrival
- drop: `RX_HELD`→`RX_HELD` on arrival without read

The transmit slot has two states: `TX_VOID` (empty) and `TX_READY`. Its transitions are:
- fill: `TX_VOID`→`TX_READY` on write
- send: `TX_READY`→`TX_VOID` on request
- refill: `TX_READY`→`TX_READY` on write

The error flag has two states: `OVR_CLEAR` and `OVR_RAISED`. Its transitions are:
- raise: on an overrun or underrun
- clear: on a clear pulse with no event in the same cycle

Top module: `i2cs_ovr_ctrl`

## Requirements
- R1: After reset, `rx_full` is 0, `tx_empty` is 1, `ovr` is 0 and `irq` is 0.
- R2: An `rx_done` pulse while the receive slot is empty stores `rx_in`. From the next cycle, `rx_full` is 1 and `rx_data` shows the byte.
- R3: Guard mode means `slave_mode`=1 and `no_stretch`=1. In guard mode, an `rx_done` while `rx_full`=1 and `sw_rd`=0 discards the new byte, keeps the held byte, and drives `rx_nack`=1 in that same cycle.
- R4: A `sw_rd` pulse empties the receive slot from the next cycle. If `sw_rd` and `rx_done` coincide while the slot is full, the new byte is stored, `rx_full` stays 1, and there is no NACK and no error.
- R5: A `sw_wr` stores `wr_data` and makes `tx_empty` 0 from the next cycle. A `tx_req` while the slot is loaded presents the stored byte on `tx_out` in that cycle. Without a write in the same cycle, `tx_empty` is 1 from the next cycle.
- R6: In guard mode, a `tx_req` while `tx_empty`=1 presents all ones on `tx_out` in that cycle (0xFF for 8-bit data). A `tx_req` is judged on the slot state at the start of the cycle, so a write in the same cycle is kept for the next request.
- R7: `ovr` becomes 1 the cycle after any overrun (R3) or underrun (R6), and stays 1 until an `ovr_clr` pulse. If a clear and a new event coincide, `ovr` stays 1.
- R8: `irq` equals `ovr` AND `err_irq_en` combinationally.
- R9: Outside guard mode (stretching on, or master mode), `ovr` is never set, `rx_nack` stays 0 and `tx_out` shows the stored byte. An arrival while full still leaves the held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1 = block acts as bus slave |
| no_stretch | input | 1 | 1 = clock stretching disabled |
| err_irq_en | input | 1 | Error interrupt enable |
| rx_done | input | 1 | Pulse: a byte finished arriving |
| rx_in | input | DATA_W | Byte delivered with `rx_done` |
| rx_nack | output | 1 | Answer the current arriving byte with NACK |
| sw_rd | input | 1 | Software reads the receive slot |
| rx_data | output | DATA_W | Receive slot contents |
| rx_full | output | 1 | Receive slot holds an unread byte |
| tx_req | input | 1 | Pulse: bus needs the next byte to send |
| tx_out | output | DATA_W | Byte to send during `tx_req` |
| tx_empty | output | 1 | Transmit slot has no fresh byte |
| sw_wr | input | 1 | Software writes the transmit slot |
| wr_data | input | DATA_W | Byte written with `sw_wr` |
| ovr_clr | input | 1 | Pulse: clear the error flag |
| ovr | output | 1 | Sticky overrun/underrun flag |
| irq | output | 1 | Error interrupt request |

## Verification
The bench builds the block with `DATA_W`=8. This makes the fill byte exactly 0xFF, so underrun output can be compared against the familiar value. Eight-bit width also makes distinct patterns such as 0xA5, 0x3C and 0x5A easy to tell apart when checking that a dropped byte never replaces a held one. The default width brings every state transition within reach in a few cycles: load, drain, reload, drop, fill, send, refill, raise and clear. It also covers the coincident cases: read plus arrival, request plus write, and clear plus event.

// File: rtl/i2cs_ovr_pkg.sv
package i2cs_ovr_pkg;
    typedef enum logic {RX_IDLE, RX_HELD} rx_state_t;
    typedef enum logic {TX_VOID, TX_READY} tx_state_t;
    typedef enum logic {OVR_CLEAR, OVR_RAISED} ovr_state_t;
endpackage

// File: rtl/i2cs_rx_slot.sv
module i2cs_rx_slot
    import i2cs_ovr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard,
    input  logic              done,
    input  logic [DATA_W-1:0] din,
    input  logic              rd,
    output logic              nack,
    output logic              overrun,
    output logic [DATA_W-1:0] dout,
    output logic              full
);
    rx_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (done) begin
                    state_d = RX_HELD;
                    load    = 1'b1;
                end
            end
            RX_HELD: begin
                if (rd && done) begin
                    load = 1'b1;
                end else if (rd) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= din;
    end

    always_comb begin
        overrun = done && (state_q == RX_HELD) && !rd && guard;
        nack    = overrun;
        dout    = data_q;
        full    = (state_q == RX_HELD);
    end

    // R3
    held_byte_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && done && !rd) |=> (dout == $past(dout)));
    // R9
    nack_needs_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> guard);
    // R4
    read_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !done) |=> !full);
endmodule

// File: rtl/i2cs_tx_slot.sv
module i2cs_tx_slot
    import i2cs_ovr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard,
    input  logic              req,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              underrun
);
    localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b1}};

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_VOID;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_VOID: begin
                if (wr) state_d = TX_READY;
            end
            TX_READY: begin
                if (!wr && req) state_d = TX_VOID;
            end
            default: state_d = TX_VOID;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  data_q <= '0;
        else if (wr) data_q <= wdata;
    end

    always_comb begin
        empty    = (state_q == TX_VOID);
        underrun = req && empty && guard;
        dout     = (underrun) ? FILL : data_q;
    end

    // R5
    send_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr) |=> empty);
    // R5
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !empty);
endmodule

// File: rtl/i2cs_ovr_flag.sv
module i2cs_ovr_flag
    import i2cs_ovr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    ovr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVR_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_CLEAR:  if (set) state_d = OVR_RAISED;
            OVR_RAISED: if (clr && !set) state_d = OVR_CLEAR;
            default:    state_d = OVR_CLEAR;
        endcase
    end

    assign flag = (state_q == OVR_RAISED);

    // R7
    event_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/i2cs_ovr_ctrl.sv
module i2cs_ovr_ctrl
    import i2cs_ovr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              no_stretch,
    input  logic              err_irq_en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_in,
    output logic              rx_nack,
    input  logic              sw_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    input  logic              tx_req,
    output logic [DATA_W-1:0] tx_out,
    output logic              tx_empty,
    input  logic              sw_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ovr_clr,
    output logic              ovr,
    output logic              irq
);
    logic guard;
    logic rx_over;
    logic tx_under;

    assign guard = slave_mode && no_stretch;

    i2cs_rx_slot #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .guard   (guard),
        .done    (rx_done),
        .din     (rx_in),
        .rd      (sw_rd),
        .nack    (rx_nack),
        .overrun (rx_over),
        .dout    (rx_data),
        .full    (rx_full)
    );

    i2cs_tx_slot #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard    (guard),
        .req      (tx_req),
        .wr       (sw_wr),
        .wdata    (wr_data),
        .dout     (tx_out),
        .empty    (tx_empty),
        .underrun (tx_under)
    );

    i2cs_ovr_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rx_over || tx_under),
        .clr   (ovr_clr),
        .flag  (ovr)
    );

    assign irq = ovr && err_irq_en;

    // R9
    no_flag_unguarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard && !ovr) |=> !ovr);
endmodule

// File: tb/i2cs_ovr_ctrl_test.sv
module i2cs_ovr_ctrl_test;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slave_mode = 1'b1, no_stretch = 1'b1, err_irq_en = 1'b1;
    logic              rx_done = 1'b0, sw_rd = 1'b0, tx_req = 1'b0, sw_wr = 1'b0, ovr_clr = 1'b0;
    logic [DATA_W-1:0] rx_in = '0, wr_data = '0;
    logic              rx_nack, rx_full, tx_empty, ovr, irq;
    logic [DATA_W-1:0] rx_data, tx_out;
    int                n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    i2cs_ovr_ctrl #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .no_stretch(no_stretch),
        .err_irq_en(err_irq_en), .rx_done(rx_done), .rx_in(rx_in), .rx_nack(rx_nack),
        .sw_rd(sw_rd), .rx_data(rx_data), .rx_full(rx_full), .tx_req(tx_req),
        .tx_out(tx_out), .tx_empty(tx_empty), .sw_wr(sw_wr), .wr_data(wr_data),
        .ovr_clr(ovr_clr), .ovr(ovr), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rx_done = 0; sw_rd = 0; tx_req = 0; sw_wr = 0; ovr_clr = 0;
    endtask

    task automatic clear_flag();
        @(negedge clk); ovr_clr = 1;
        idle();
    endtask

    task automatic t_reset();
        chk("R1 rx_full", rx_full, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 ovr", ovr, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_rx_accept();
        @(negedge clk); rx_done = 1; rx_in = 8'hA5; #1;
        chk("R2 nack", rx_nack, 0);
        idle();
        chk("R2 full", rx_full, 1);
        chk("R2 data", rx_data, 8'hA5);
    endtask

    task automatic t_rx_overrun();
        @(negedge clk); rx_done = 1; rx_in = 8'h3C; #1;
        chk("R3 nack", rx_nack, 1);
        idle();
        chk("R3 kept", rx_data, 8'hA5);
        chk("R7 ovr set", ovr, 1);
        chk("R8 irq", irq, 1);
        err_irq_en = 0; #1;
        chk("R8 masked", irq, 0);
        err_irq_en = 1;
        @(negedge clk); sw_rd = 1;
        idle();
        chk("R4 drained", rx_full, 0);
        chk("R7 sticky", ovr, 1);
        clear_flag();
        chk("R7 cleared", ovr, 0);
    endtask

    task automatic t_rx_coincide();
        @(negedge clk); rx_done = 1; rx_in = 8'h11;
        @(negedge clk); rx_done = 1; rx_in = 8'h22; sw_rd = 1; #1;
        chk("R4 no nack", rx_nack, 0);
        idle();
        chk("R4 full", rx_full, 1);
        chk("R4 new byte", rx_data, 8'h22);
        chk("R4 no ovr", ovr, 0);
        @(negedge clk); sw_rd = 1;
        idle();
    endtask

    task automatic t_tx_underrun();
        @(negedge clk); tx_req = 1; #1;
        chk("R6 fill", tx_out, 8'hFF);
        idle();
        chk("R7 ovr tx", ovr, 1);
        // set and clear together: set wins
        @(negedge clk); tx_req = 1; ovr_clr = 1;
        idle();
        chk("R7 set wins", ovr, 1);
        clear_flag();
    endtask

    task automatic t_tx_normal();
        @(negedge clk); sw_wr = 1; wr_data = 8'h5A;
        idle();
        chk("R5 loaded", tx_empty, 0);
        @(negedge clk); tx_req = 1; #1;
        chk("R5 data", tx_out, 8'h5A);
        idle();
        chk("R5 empty", tx_empty, 1);
        chk("R5 no ovr", ovr, 0);
        // request and write together while empty: fill, write kept
        @(negedge clk); tx_req = 1; sw_wr = 1; wr_data = 8'h77; #1;
        chk("R6 fill with write", tx_out, 8'hFF);
        idle();
        chk("R6 write kept", tx_empty, 0);
        @(negedge clk); tx_req = 1; #1;
        chk("R6 next sends write", tx_out, 8'h77);
        idle();
        clear_flag();
    endtask

    task automatic t_unguarded(input logic sm, input logic ns);
        slave_mode = sm; no_stretch = ns;
        @(negedge clk); rx_done = 1; rx_in = 8'h44;
        @(negedge clk); rx_done = 1; rx_in = 8'h55; #1;
        chk("R9 no nack", rx_nack, 0);
        idle();
        chk("R9 kept", rx_data, 8'h44);
        @(negedge clk); tx_req = 1; #1;
        chk("R9 no fill", tx_out, 8'h77);
        idle();
        chk("R9 no ovr", ovr, 0);
        @(negedge clk); sw_rd = 1;
        idle();
        slave_mode = 1; no_stretch = 1;
    endtask

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        idle();
        t_reset();
        t_rx_accept();
        t_rx_overrun();
        t_rx_coincide();
        t_tx_underrun();
        t_tx_normal();
        t_unguarded(1'b1, 1'b0);
        t_unguarded(1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule